// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a small, fully associative store of recently used virtual-to-physical address translations. A lookup presents a 32-bit virtual address together with the current 8-bit process identifier. When a stored entry matches, the block returns three things in the same cycle, with no register in the path: the physical address, the entry's domain number and its permission bits. When no entry matches, it raises a miss flag. An external page table walker answers the miss and writes the result back through a one-cycle fill port. A single invalidate-all pulse empties the whole store.

Each entry maps one of four region sizes: 4 KB, 64 KB, 1 MB or 16 MB. The entry's size code sets which virtual address bits take part in the tag compare and which bits pass straight through as the offset. A single entry therefore covers a whole large region. Each entry also carries a process-specific flag. When that flag is clear, the entry matches under any process identifier. When it is set, the stored identifier must equal the current one.

Top module: `mslb_tlb`

## Requirements
- R1: After reset no entry is valid, so every enabled lookup reports miss=1 and hit=0.
- R2: A size-code-0 (4 KB) entry matches on virtual address bits 31:12. On a hit, pa = {stored frame bits 31:12, va[11:0]}, and hit_dom and hit_perm carry the stored fields, all in the same cycle as the lookup.
- R3: A size-code-1 (64 KB) entry compares bits 31:16. pa[31:16] comes from the entry and pa[15:0] from the virtual address.
- R4: A size-code-2 (1 MB) entry compares bits 31:20. pa[31:20] comes from the entry and pa[19:0] from the virtual address.
- R5: A size-code-3 (16 MB) entry compares bits 31:24. pa[31:24] comes from the entry and pa[23:0] from the virtual address. Stored page and frame bits below the region boundary are ignored.
- R6: An entry filled with fill_ng=0 (global) hits whatever the value of cur_asid.
- R7: An entry filled with fill_ng=1 hits only when cur_asid equals the stored fill_asid.
- R8: With lookup_en=1 and no matching entry, miss=1 and hit=0. With lookup_en=0, both hit and miss are 0.
- R9: A fill writes the lowest-numbered invalid entry when one exists. Starting from empty, 32 fills therefore all stay resident.
- R10: When every entry is valid, fills replace entries in round-robin order starting from entry 0. The first such fill evicts the oldest entry, and the next evicts the second oldest.
- R11: If two valid entries match, the lower-numbered entry supplies the result.
- R12: inval_all clears every entry on the next clock edge. It takes priority over a fill in the same cycle, and it returns the round-robin pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_en | input | 1 | Lookup request qualifier |
| lookup_va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current process identifier |
| hit | output | 1 | A valid entry matched |
| miss | output | 1 | Enabled lookup found no entry |
| pa | output | 32 | Translated physical address (valid when hit=1) |
| hit_dom | output | 4 | Domain number of the matching entry |
| hit_perm | output | 3 | Permission bits of the matching entry |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | 20 | Virtual page bits 31:12 of the new entry |
| fill_ppn | input | 20 | Physical frame bits 31:12 of the new entry |
| fill_size | input | 2 | Size code: 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| fill_ng | input | 1 | 1 = process-specific, 0 = global |
| fill_asid | input | 8 | Process identifier stored with the entry |
| fill_dom | input | 4 | Domain number stored with the entry |
| fill_perm | input | 3 | Permission bits stored with the entry |
| inval_all | input | 1 | Clear every entry |

## Verification
Round-robin eviction is the hardest behaviour to reach from the ports. It only takes effect once all 32 entries are valid, and the victim's index is never visible. The stimulus empties the store with inval_all and fills 32 distinct 4 KB pages in a known order. It confirms that all 32 pages still hit, then adds two more fills and checks that exactly the first and then the second page start to miss while a later page still hits. The tie between two matching entries is reached the same way: two fills of the same page after a clear place the first copy in entry 0, so the expected winner is known.

// File: rtl/mslb_tlb.sv
module mslb_tlb #(
  parameter int ENTRIES = 32,
  parameter int ASID_W  = 8,
  parameter int DOM_W   = 4,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_en,
  input  logic [31:0]       lookup_va,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              hit,
  output logic              miss,
  output logic [31:0]       pa,
  output logic [DOM_W-1:0]  hit_dom,
  output logic [PERM_W-1:0] hit_perm,
  input  logic              fill_en,
  input  logic [19:0]       fill_vpn,
  input  logic [19:0]       fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic              fill_ng,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inval_all
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [19:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 20'hFFFFF;
      2'd1:    return 20'hFFFF0;
      2'd2:    return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

  logic [ENTRIES-1:0] valid;
  logic [19:0]        e_vpn  [ENTRIES];
  logic [19:0]        e_ppn  [ENTRIES];
  logic [1:0]         e_size [ENTRIES];
  logic               e_ng   [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [DOM_W-1:0]   e_dom  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g]
                    && (((lookup_va[31:12] ^ e_vpn[g]) & size_mask(e_size[g])) == 20'd0)
                    && (!e_ng[g] || (e_asid[g] == cur_asid));
  end

  logic [19:0]       sel_ppn, sel_mask;
  logic [DOM_W-1:0]  sel_dom;
  logic [PERM_W-1:0] sel_perm;
  always_comb begin
    sel_ppn  = '0;
    sel_mask = '1;
    sel_dom  = '0;
    sel_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_ppn  = e_ppn[i];
        sel_mask = size_mask(e_size[i]);
        sel_dom  = e_dom[i];
        sel_perm = e_perm[i];
      end
    end
  end

  assign hit      = lookup_en && (|match);
  assign miss     = lookup_en && !(|match);
  assign pa       = {(sel_ppn & sel_mask) | (lookup_va[31:12] & ~sel_mask), lookup_va[11:0]};
  assign hit_dom  = sel_dom;
  assign hit_perm = sel_perm;

  logic             any_free;
  logic [IDX_W-1:0] free_idx, victim;
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  assign victim = any_free ? free_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n || inval_all) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else if (fill_en) begin
      valid[victim] <= 1'b1;
      if (!any_free) rr_ptr <= rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[victim]  <= fill_vpn;
      e_ppn[victim]  <= fill_ppn;
      e_size[victim] <= fill_size;
      e_ng[victim]   <= fill_ng;
      e_asid[victim] <= fill_asid;
      e_dom[victim]  <= fill_dom;
      e_perm[victim] <= fill_perm;
    end
  end

  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (valid == '0) && !hit);

  assert_fill_takes_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inval_all && !(&valid)) |=>
      ($countones(valid) == $past($countones(valid)) + 1));

  assert_offset_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[11:0] == lookup_va[11:0]));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_en |-> (!hit && !miss));

endmodule

// File: tb/mslb_tlb_tb.sv
module mslb_tlb_tb;
  logic        clk = 0, rst_n = 0;
  logic        lookup_en = 0;
  logic [31:0] lookup_va = 0;
  logic [7:0]  cur_asid = 0;
  logic        hit, miss;
  logic [31:0] pa;
  logic [3:0]  hit_dom;
  logic [2:0]  hit_perm;
  logic        fill_en = 0, fill_ng = 0, inval_all = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic [1:0]  fill_size = 0;
  logic [7:0]  fill_asid = 0;
  logic [3:0]  fill_dom = 0;
  logic [2:0]  fill_perm = 0;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  mslb_tlb u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] sz,
                      input logic ng, input logic [7:0] asid, input logic [3:0] dom,
                      input logic [2:0] perm);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_size = sz;
    fill_ng = ng; fill_asid = asid; fill_dom = dom; fill_perm = perm;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    lookup_en = 1; lookup_va = va; cur_asid = asid;
    #1;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] va, input logic [7:0] asid,
                            input logic [31:0] exp_pa);
    look(va, asid);
    chk({tag, " hit"}, {31'd0, hit}, 32'd1);
    chk({tag, " pa"}, pa, exp_pa);
  endtask

  task automatic expect_miss(input string tag, input logic [31:0] va, input logic [7:0] asid);
    look(va, asid);
    chk({tag, " hit"}, {31'd0, hit}, 32'd0);
    chk({tag, " miss"}, {31'd0, miss}, 32'd1);
  endtask

  task automatic t_reset();
    expect_miss("R1 empty after reset", 32'h1234_5678, 8'd0);
    @(negedge clk); lookup_en = 0; #1;
    chk("R8 idle hit", {31'd0, hit}, 32'd0);
    chk("R8 idle miss", {31'd0, miss}, 32'd0);
  endtask

  task automatic t_sizes();
    fill(20'h12345, 20'hABCDE, 2'd0, 1'b0, 8'd0, 4'd5, 3'd3);
    expect_hit("R2 small", 32'h1234_5678, 8'd9, 32'hABCD_E678);
    chk("R2 dom", {28'd0, hit_dom}, 32'd5);
    chk("R2 perm", {29'd0, hit_perm}, 32'd3);
    expect_miss("R8 neighbour page", 32'h1234_6678, 8'd9);
    fill(20'h20010, 20'h55550, 2'd1, 1'b0, 8'd0, 4'd1, 3'd1);
    expect_hit("R3 large", 32'h2001_ABCD, 8'd0, 32'h5555_ABCD);
    expect_miss("R3 outside", 32'h2002_0000, 8'd0);
    fill(20'h30000, 20'h77700, 2'd2, 1'b0, 8'd0, 4'd2, 3'd2);
    expect_hit("R4 section", 32'h300F_1234, 8'd0, 32'h777F_1234);
    expect_miss("R4 outside", 32'h3010_0000, 8'd0);
    fill(20'h41234, 20'h9A123, 2'd3, 1'b0, 8'd0, 4'd3, 3'd4);
    expect_hit("R5 supersection", 32'h41FE_DCBA, 8'd0, 32'h9AFE_DCBA);
    chk("R5 dom", {28'd0, hit_dom}, 32'd3);
    expect_miss("R5 outside", 32'h4200_0000, 8'd0);
  endtask

  task automatic t_asid();
    clear_all();
    fill(20'h50000, 20'h11111, 2'd0, 1'b1, 8'd7, 4'd0, 3'd0);
    expect_hit("R7 same id", 32'h5000_0ABC, 8'd7, 32'h1111_1ABC);
    expect_miss("R7 other id", 32'h5000_0ABC, 8'd8);
    fill(20'h60000, 20'h22222, 2'd0, 1'b0, 8'd7, 4'd0, 3'd0);
    expect_hit("R6 global", 32'h6000_0123, 8'd200, 32'h2222_2123);
  endtask

  task automatic t_dup();
    clear_all();
    fill(20'h70000, 20'h01000, 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    fill(20'h70000, 20'h02000, 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    expect_hit("R11 lowest wins", 32'h7000_0444, 8'd0, 32'h0100_0444);
  endtask

  task automatic t_replace();
    clear_all();
    for (int i = 0; i < 32; i++)
      fill(20'h00100 + 20'(i), 20'h80000 + 20'(i), 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    for (int i = 0; i < 32; i++)
      expect_hit("R9 all resident", {20'h00100 + 20'(i), 12'h010}, 8'd0,
                 {20'h80000 + 20'(i), 12'h010});
    fill(20'h00400, 20'h90000, 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    expect_miss("R10 first evicted", 32'h0010_0000, 8'd0);
    expect_hit("R10 second kept", 32'h0010_1000, 8'd0, 32'h8000_1000);
    expect_hit("R10 new present", 32'h0040_0000, 8'd0, 32'h9000_0000);
    fill(20'h00401, 20'h90001, 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    expect_miss("R10 second evicted", 32'h0010_1000, 8'd0);
    expect_hit("R10 third kept", 32'h0010_2000, 8'd0, 32'h8000_2000);
  endtask

  task automatic t_inval();
    fill(20'hA0000, 20'hB0000, 2'd0, 1'b0, 8'd0, 4'd0, 3'd0);
    @(negedge clk);
    inval_all = 1; fill_en = 1; fill_vpn = 20'hC0000; fill_ppn = 20'hD0000;
    fill_size = 0; fill_ng = 0;
    @(negedge clk);
    inval_all = 0; fill_en = 0;
    expect_miss("R12 old cleared", 32'hA000_0000, 8'd0);
    expect_miss("R12 fill dropped", 32'hC000_0000, 8'd0);
    expect_miss("R12 others cleared", 32'h0010_2000, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sizes();
    t_asid();
    t_dup();
    t_replace();
    t_inval();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule